// File: doc/BRIEF.md
# Local Interrupt Controller Register Front End

This block is the 32-bit memory-mapped register interface of a local interrupt controller. A single-beat register bus brings in a byte address, a write flag, byte enables and write data. The register index comes from address bits [11:4], which selects one of the controller's registers. The block holds the writable state itself: identifier, task priority, logical identifier, destination model, spurious vector, error status, the two command words, the local vector table entries, the timer initial count and the divide setting. Live values from neighbouring logic are passed through on reads: the in-service, trigger-mode and pending vector arrays, the processor priority and the current timer count.

Some writes are events as well as stores. A write to the low command word launches an interprocessor send. A write to the end-of-interrupt index signals the priority logic. A vector table write or an initial-count write tells the timer and the local sources that their setting changed. Each of these events leaves the block as a one-cycle pulse in the cycle after the bus access. Any access that is not a full 32-bit word has no effect. A full access to an index that the map does not define sets a sticky error bit.

Top module: `intc_reg_front`

## Requirements
- R1: After reset the identifier, task priority, logical identifier, error status, both command words, initial count and divide setting read zero. The model nibble reads 4'hF, the spurious register reads 9'h0FF, and every vector table entry reads 32'h0001_0000 (masked).
- R2: A full write to index 0x02 (identifier) or index 0x0D (logical identifier) keeps wdata[31:24]. A read returns that byte in bits [31:24] with zeros below, and the byte also appears on its output port.
- R3: Index 0x03 reads {8'h00, NUM_LVT-1, 8'h00, VERSION} (table size minus one in bits [23:16], version in bits [7:0]). Writes to it change nothing.
- R4: Index 0x0E reads the 4-bit model in bits [31:28] with bits [27:0] all ones. A write keeps wdata[31:28].
- R5: Index 0x0F keeps only wdata[8:0]. Bit 8 is the software enable. The stored value reads back zero-extended and drives svr_o.
- R6: Index 0x10+w, 0x18+w and 0x20+w (w = 0..7) read 32-bit word w (bits 32w+31 to 32w) of the in-service, trigger-mode and pending inputs. Writes to these indices, to index 0x28 (error status) and to index 0x39 (current count) change no register and set no error.
- R7: A write to index 0x31 stores the high command word. A write to index 0x30 stores the low word, and during the next cycle send_o is high for exactly one cycle. With that pulse come the destination from high word bits [31:24], the vector from bits [7:0], the delivery mode from bits [10:8], the destination mode from bit 11 and the trigger mode from bit 15. Both words read back as written.
- R8: Index 0x3E keeps wdata & 4'hB. The effective shift is ({bit3, bit1, bit0} + 1) mod 8 and drives div_shift_o.
- R9: A full read or write to an undefined index sets error bit 7 (value 8'h80). The bit stays set until reset, and an undefined read returns zero.
- R10: A full write to index 0x0B pulses eoi_o for one cycle in the next cycle, and the index reads zero. Index 0x0A reads ppr_val zero-extended, and index 0x09 reads zero.
- R11: An access whose byte enables are not all ones is ignored. It changes no register, sets no error and fires no pulse, and a read of that kind returns zero.
- R12: A write to index 0x32+n (n < NUM_LVT) stores the whole word in entry n and pulses lvt_wr_o[n] for one cycle. A write to index 0x38 stores the initial count and pulses init_wr_o. Index 0x39 reads cur_count.
- R13: Index 0x08 keeps wdata[7:0] as task priority, reads it zero-extended and drives tpr_o.
- R14: bus_ready is always high. Every read request gives rsp_valid for one cycle, with its data in the cycle after the request, and a write gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [11:4] form the index |
| bus_be | input | 4 | Byte enables; only 4'hF is acted on |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Always high |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| isr_bits | input | 32*ARR_WORDS | In-service vector array |
| tmr_bits | input | 32*ARR_WORDS | Trigger-mode vector array |
| irr_bits | input | 32*ARR_WORDS | Pending vector array |
| ppr_val | input | 8 | Processor priority from priority logic |
| cur_count | input | 32 | Current timer count |
| id_o | output | 8 | Identifier |
| tpr_o | output | 8 | Task priority |
| ldr_o | output | 8 | Logical identifier |
| model_o | output | 4 | Destination model nibble |
| svr_o | output | 9 | Spurious vector and enable |
| esr_o | output | 8 | Error status |
| lvt_o | output | 32*NUM_LVT | Vector table entries, entry n at bits 32n+31 to 32n |
| lvt_wr_o | output | NUM_LVT | One-cycle write pulse per entry |
| init_count_o | output | 32 | Timer initial count |
| init_wr_o | output | 1 | Initial count written pulse |
| div_shift_o | output | 3 | Effective divide shift |
| eoi_o | output | 1 | End-of-interrupt pulse |
| send_o | output | 1 | Command send pulse |
| send_dest_o | output | 8 | Send destination |
| send_vec_o | output | 8 | Send vector |
| send_dmode_o | output | 3 | Send delivery mode |
| send_destmode_o | output | 1 | Send destination mode |
| send_trig_o | output | 1 | Send trigger mode |

## Verification
The bench uses the default parameters: NUM_LVT = 6, ARR_WORDS = 8 and VERSION = 8'h14. The version word therefore carries 5 in its size field, and the six table indices end exactly where the initial-count index begins. With all eight array words present, the first and last word of each vector array can be read. The edge between the last table entry and the timer registers is also covered, as is the divide remapping for all sixteen write values.

// File: rtl/intc_reg_pkg.sv
package intc_reg_pkg;

  typedef enum logic [4:0] {
    RK_ID, RK_VER, RK_TPR, RK_APR, RK_PPR, RK_EOI, RK_LDR, RK_DFR, RK_SVR,
    RK_ISR, RK_TMR, RK_IRR, RK_ESR, RK_ICRL, RK_ICRH, RK_LVT, RK_INIT,
    RK_CUR, RK_DIV, RK_BAD
  } reg_kind_e;

  localparam logic [7:0]  ESR_BAD_ADDR = 8'h80;
  localparam logic [31:0] LVT_RESET    = 32'h0001_0000;
  localparam logic [7:0]  LVT_BASE     = 8'h32;

  // Divide setting: bit3 lands on shift bit 2, then add one, wrap at 8.
  function automatic logic [2:0] div_to_shift(input logic [3:0] d);
    logic [2:0] v;
    v = {d[3], d[1:0]};
    return v + 3'd1;
  endfunction

  function automatic logic [31:0] version_word(input logic [7:0] ver,
                                               input int unsigned nlvt);
    logic [7:0] top;
    top = 8'(nlvt - 1);
    return {8'h00, top, 8'h00, ver};
  endfunction

endpackage

// File: rtl/intc_reg_decode.sv
module intc_reg_decode
  import intc_reg_pkg::*;
#(
  parameter int NUM_LVT   = 6,
  parameter int LVT_SEL_W = 3
) (
  input  logic [7:0]           idx,
  output reg_kind_e            kind,
  output logic [2:0]           word,
  output logic [LVT_SEL_W-1:0] lvt_sel
);
  localparam int LVT_LO = int'(LVT_BASE);
  localparam int LVT_HI = LVT_LO + NUM_LVT;

  always_comb begin
    word    = idx[2:0];
    lvt_sel = LVT_SEL_W'(idx - LVT_BASE);
    kind    = RK_BAD;
    if (int'(idx) >= LVT_LO && int'(idx) < LVT_HI) begin
      kind = RK_LVT;
    end else begin
      unique case (idx)
        8'h02: kind = RK_ID;
        8'h03: kind = RK_VER;
        8'h08: kind = RK_TPR;
        8'h09: kind = RK_APR;
        8'h0A: kind = RK_PPR;
        8'h0B: kind = RK_EOI;
        8'h0D: kind = RK_LDR;
        8'h0E: kind = RK_DFR;
        8'h0F: kind = RK_SVR;
        8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17: kind = RK_ISR;
        8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h1F: kind = RK_TMR;
        8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27: kind = RK_IRR;
        8'h28: kind = RK_ESR;
        8'h30: kind = RK_ICRL;
        8'h31: kind = RK_ICRH;
        8'h38: kind = RK_INIT;
        8'h39: kind = RK_CUR;
        8'h3E: kind = RK_DIV;
        default: kind = RK_BAD;
      endcase
    end
  end
endmodule

// File: rtl/intc_reg_store.sv
module intc_reg_store
  import intc_reg_pkg::*;
#(
  parameter int NUM_LVT   = 6,
  parameter int LVT_SEL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    err_set,
  input  reg_kind_e               kind,
  input  logic [LVT_SEL_W-1:0]    lvt_sel,
  input  logic [31:0]             wdata,
  output logic [7:0]              id_q,
  output logic [7:0]              tpr_q,
  output logic [7:0]              ldr_q,
  output logic [3:0]              model_q,
  output logic [8:0]              svr_q,
  output logic [7:0]              esr_q,
  output logic [31:0]             icr_lo_q,
  output logic [31:0]             icr_hi_q,
  output logic [NUM_LVT*32-1:0]   lvt_flat,
  output logic [31:0]             init_q,
  output logic [3:0]              div_q,
  output logic [NUM_LVT-1:0]      lvt_wr,
  output logic                    init_wr,
  output logic                    eoi,
  output logic                    send,
  output logic [7:0]              send_dest,
  output logic [7:0]              send_vec,
  output logic [2:0]              send_dmode,
  output logic                    send_destmode,
  output logic                    send_trig
);
  // named write events, one per register group
  logic ev_send, ev_eoi, ev_init, ev_lvt;
  assign ev_send = wr_en && (kind == RK_ICRL);
  assign ev_eoi  = wr_en && (kind == RK_EOI);
  assign ev_init = wr_en && (kind == RK_INIT);
  assign ev_lvt  = wr_en && (kind == RK_LVT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q <= '0; tpr_q <= '0; ldr_q <= '0; model_q <= 4'hF;
      svr_q <= 9'h0FF; esr_q <= '0; icr_lo_q <= '0; icr_hi_q <= '0;
      init_q <= '0; div_q <= '0;
      init_wr <= 1'b0; eoi <= 1'b0; send <= 1'b0;
      send_dest <= '0; send_vec <= '0; send_dmode <= '0;
      send_destmode <= 1'b0; send_trig <= 1'b0;
    end else begin
      init_wr <= ev_init;
      eoi     <= ev_eoi;
      send    <= ev_send;
      if (err_set) esr_q <= esr_q | ESR_BAD_ADDR;
      if (ev_send) begin
        send_dest     <= icr_hi_q[31:24];
        send_vec      <= wdata[7:0];
        send_dmode    <= wdata[10:8];
        send_destmode <= wdata[11];
        send_trig     <= wdata[15];
      end
      if (wr_en) begin
        case (kind)
          RK_ID:   id_q     <= wdata[31:24];
          RK_TPR:  tpr_q    <= wdata[7:0];
          RK_LDR:  ldr_q    <= wdata[31:24];
          RK_DFR:  model_q  <= wdata[31:28];
          RK_SVR:  svr_q    <= wdata[8:0];
          RK_ICRL: icr_lo_q <= wdata;
          RK_ICRH: icr_hi_q <= wdata;
          RK_INIT: init_q   <= wdata;
          RK_DIV:  div_q    <= wdata[3:0] & 4'hB;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt
    logic hit;
    assign hit = ev_lvt && (lvt_sel == LVT_SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvt_flat[g*32 +: 32] <= LVT_RESET;
        lvt_wr[g]            <= 1'b0;
      end else begin
        lvt_wr[g] <= hit;
        if (hit) lvt_flat[g*32 +: 32] <= wdata;
      end
    end
  end

  // R7/R10/R12: at most one event pulse per cycle
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send, eoi, init_wr, |lvt_wr}))
    else $error("event pulses overlap");

  // R9: error bit is sticky
  p_esr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    esr_q[7] |=> esr_q[7])
    else $error("error bit cleared");

  // R7: a send pulse lasts exactly one cycle when no new send follows
  p_send_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (send && !ev_send) |=> !send)
    else $error("send pulse stretched");
endmodule

// File: rtl/intc_reg_rdmux.sv
module intc_reg_rdmux
  import intc_reg_pkg::*;
#(
  parameter int         NUM_LVT   = 6,
  parameter int         LVT_SEL_W = 3,
  parameter int         ARR_WORDS = 8,
  parameter logic [7:0] VERSION   = 8'h14
) (
  input  reg_kind_e                kind,
  input  logic [2:0]               word,
  input  logic [LVT_SEL_W-1:0]     lvt_sel,
  input  logic [ARR_WORDS*32-1:0]  isr_bits,
  input  logic [ARR_WORDS*32-1:0]  tmr_bits,
  input  logic [ARR_WORDS*32-1:0]  irr_bits,
  input  logic [7:0]               ppr_val,
  input  logic [31:0]              cur_count,
  input  logic [7:0]               id_q,
  input  logic [7:0]               tpr_q,
  input  logic [7:0]               ldr_q,
  input  logic [3:0]               model_q,
  input  logic [8:0]               svr_q,
  input  logic [7:0]               esr_q,
  input  logic [31:0]              icr_lo_q,
  input  logic [31:0]              icr_hi_q,
  input  logic [NUM_LVT*32-1:0]    lvt_flat,
  input  logic [31:0]              init_q,
  input  logic [3:0]               div_q,
  output logic [31:0]              rdata
);
  logic word_ok;
  assign word_ok = 32'(word) < ARR_WORDS;

  always_comb begin
    rdata = '0;
    unique case (kind)
      RK_ID:   rdata = {id_q, 24'h0};
      RK_VER:  rdata = version_word(VERSION, NUM_LVT);
      RK_TPR:  rdata = {24'h0, tpr_q};
      RK_APR:  rdata = '0;
      RK_PPR:  rdata = {24'h0, ppr_val};
      RK_EOI:  rdata = '0;
      RK_LDR:  rdata = {ldr_q, 24'h0};
      RK_DFR:  rdata = {model_q, 28'hFFF_FFFF};
      RK_SVR:  rdata = {23'h0, svr_q};
      RK_ISR:  rdata = word_ok ? isr_bits[32*word +: 32] : '0;
      RK_TMR:  rdata = word_ok ? tmr_bits[32*word +: 32] : '0;
      RK_IRR:  rdata = word_ok ? irr_bits[32*word +: 32] : '0;
      RK_ESR:  rdata = {24'h0, esr_q};
      RK_ICRL: rdata = icr_lo_q;
      RK_ICRH: rdata = icr_hi_q;
      RK_LVT:  rdata = lvt_flat[32*lvt_sel +: 32];
      RK_INIT: rdata = init_q;
      RK_CUR:  rdata = cur_count;
      RK_DIV:  rdata = {28'h0, div_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_reg_front.sv
module intc_reg_front
  import intc_reg_pkg::*;
#(
  parameter int         NUM_LVT   = 6,
  parameter int         ARR_WORDS = 8,
  parameter logic [7:0] VERSION   = 8'h14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [11:0]              bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic                     bus_ready,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  input  logic [ARR_WORDS*32-1:0]  isr_bits,
  input  logic [ARR_WORDS*32-1:0]  tmr_bits,
  input  logic [ARR_WORDS*32-1:0]  irr_bits,
  input  logic [7:0]               ppr_val,
  input  logic [31:0]              cur_count,
  output logic [7:0]               id_o,
  output logic [7:0]               tpr_o,
  output logic [7:0]               ldr_o,
  output logic [3:0]               model_o,
  output logic [8:0]               svr_o,
  output logic [7:0]               esr_o,
  output logic [NUM_LVT*32-1:0]    lvt_o,
  output logic [NUM_LVT-1:0]       lvt_wr_o,
  output logic [31:0]              init_count_o,
  output logic                     init_wr_o,
  output logic [2:0]               div_shift_o,
  output logic                     eoi_o,
  output logic                     send_o,
  output logic [7:0]               send_dest_o,
  output logic [7:0]               send_vec_o,
  output logic [2:0]               send_dmode_o,
  output logic                     send_destmode_o,
  output logic                     send_trig_o
);
  localparam int LVT_SEL_W = (NUM_LVT > 1) ? $clog2(NUM_LVT) : 1;

  reg_kind_e              kind;
  logic [2:0]             word;
  logic [LVT_SEL_W-1:0]   lvt_sel;
  logic                   full_acc, wr_en, rd_en, err_set;
  logic [31:0]            icr_lo_q, icr_hi_q, mux_data;
  logic [3:0]             div_q;

  assign bus_ready = 1'b1;
  assign full_acc  = bus_valid && (bus_be == 4'hF);
  assign wr_en     = full_acc && bus_write;
  assign rd_en     = bus_valid && !bus_write;
  assign err_set   = full_acc && (kind == RK_BAD);

  intc_reg_decode #(.NUM_LVT(NUM_LVT), .LVT_SEL_W(LVT_SEL_W)) u_dec (
    .idx(bus_addr[11:4]), .kind(kind), .word(word), .lvt_sel(lvt_sel));

  intc_reg_store #(.NUM_LVT(NUM_LVT), .LVT_SEL_W(LVT_SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .err_set(err_set), .kind(kind),
    .lvt_sel(lvt_sel), .wdata(bus_wdata),
    .id_q(id_o), .tpr_q(tpr_o), .ldr_q(ldr_o), .model_q(model_o),
    .svr_q(svr_o), .esr_q(esr_o), .icr_lo_q(icr_lo_q), .icr_hi_q(icr_hi_q),
    .lvt_flat(lvt_o), .init_q(init_count_o), .div_q(div_q),
    .lvt_wr(lvt_wr_o), .init_wr(init_wr_o), .eoi(eoi_o), .send(send_o),
    .send_dest(send_dest_o), .send_vec(send_vec_o), .send_dmode(send_dmode_o),
    .send_destmode(send_destmode_o), .send_trig(send_trig_o));

  intc_reg_rdmux #(.NUM_LVT(NUM_LVT), .LVT_SEL_W(LVT_SEL_W),
                   .ARR_WORDS(ARR_WORDS), .VERSION(VERSION)) u_mux (
    .kind(kind), .word(word), .lvt_sel(lvt_sel),
    .isr_bits(isr_bits), .tmr_bits(tmr_bits), .irr_bits(irr_bits),
    .ppr_val(ppr_val), .cur_count(cur_count),
    .id_q(id_o), .tpr_q(tpr_o), .ldr_q(ldr_o), .model_q(model_o),
    .svr_q(svr_o), .esr_q(esr_o), .icr_lo_q(icr_lo_q), .icr_hi_q(icr_hi_q),
    .lvt_flat(lvt_o), .init_q(init_count_o), .div_q(div_q), .rdata(mux_data));

  assign div_shift_o = div_to_shift(div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= (rd_en && full_acc) ? mux_data : '0;
    end
  end

  // R14: every read gets a response next cycle, writes get none
  p_rd_resp_r14: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> (rsp_valid == !$past(bus_write)))
    else $error("response mismatch");

  // R11: a narrow access leaves stored state and error status alone
  p_narrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_be != 4'hF) |=>
      ($stable(id_o) && $stable(tpr_o) && $stable(esr_o) && $stable(lvt_o)
       && !send_o && !eoi_o))
    else $error("narrow access had an effect");

  // R10: full write to the EOI index pulses eoi_o next cycle
  p_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_be == 4'hF && bus_addr[11:4] == 8'h0B)
      |=> eoi_o)
    else $error("missing eoi pulse");

  // R7: low command word write launches a send carrying its vector
  p_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_be == 4'hF && bus_addr[11:4] == 8'h30)
      |=> (send_o && send_vec_o == $past(bus_wdata[7:0])))
    else $error("send not launched");
endmodule

// File: tb/intc_reg_front_bench.sv
module intc_reg_front_bench;
  localparam int NL = 6;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [AW*32-1:0] isr_bits = '0, tmr_bits = '0, irr_bits = '0;
  logic [7:0]  ppr_val = '0;
  logic [31:0] cur_count = '0;
  logic [7:0]  id_o, tpr_o, ldr_o, esr_o, send_dest_o, send_vec_o;
  logic [3:0]  model_o;
  logic [8:0]  svr_o;
  logic [NL*32-1:0] lvt_o;
  logic [NL-1:0] lvt_wr_o;
  logic [31:0] init_count_o;
  logic init_wr_o, eoi_o, send_o, send_destmode_o, send_trig_o;
  logic [2:0] div_shift_o, send_dmode_o;

  intc_reg_front u_intc_reg_front (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] rd;
  logic [NL-1:0] p_lvt;
  logic p_init, p_eoi, p_send;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ad(input int idx);
    return 12'(idx * 16);
  endfunction

  function automatic logic [2:0] exp_shift(input logic [3:0] d);
    int v;
    v = (int'(d) & 3) | ((int'(d) >> 1) & 4);
    return 3'((v + 1) % 8);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    p_lvt = lvt_wr_o; p_init = init_wr_o; p_eoi = eoi_o; p_send = send_o;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d,
                       input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R14 rsp_valid", 32'(rsp_valid), 1);
    d = rsp_rdata;
    bus_valid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] exp_lvt [NL];
    logic [3:0] dv;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    rdreg(ad(8'h02), rd); chk(rd == 0, "R1 id", rd, 0);
    rdreg(ad(8'h0E), rd); chk(rd == 32'hFFFF_FFFF, "R1 model", rd, 32'hFFFF_FFFF);
    rdreg(ad(8'h0F), rd); chk(rd == 32'h0FF, "R1 svr", rd, 32'h0FF);
    for (int n = 0; n < NL; n++) begin
      rdreg(ad(8'h32 + n), rd); chk(rd == 32'h0001_0000, "R1 lvt", rd, 32'h0001_0000);
      exp_lvt[n] = 32'h0001_0000;
    end
    chk(esr_o == 0, "R1 esr", 32'(esr_o), 0);
    chk(bus_ready == 1, "R14 ready", 32'(bus_ready), 1);

    // R3 version
    wr(ad(8'h03), 32'hFFFF_FFFF);
    rdreg(ad(8'h03), rd); chk(rd == 32'h0005_0014, "R3 version", rd, 32'h0005_0014);

    // R2 id / logical id
    wr(ad(8'h02), 32'hA5_123456);
    rdreg(ad(8'h02), rd); chk(rd == 32'hA500_0000, "R2 id", rd, 32'hA500_0000);
    chk(id_o == 8'hA5, "R2 id_o", 32'(id_o), 32'hA5);
    wr(ad(8'h0D), 32'h3C_FFFFFF);
    rdreg(ad(8'h0D), rd); chk(rd == 32'h3C00_0000, "R2 ldr", rd, 32'h3C00_0000);

    // R4 format
    wr(ad(8'h0E), 32'h0123_4567);
    rdreg(ad(8'h0E), rd); chk(rd == 32'h0FFF_FFFF, "R4 model", rd, 32'h0FFF_FFFF);

    // R5 spurious
    wr(ad(8'h0F), 32'hFFFF_FE55);
    rdreg(ad(8'h0F), rd); chk(rd == 32'h055, "R5 svr", rd, 32'h055);
    chk(svr_o[8] == 0, "R5 enable", 32'(svr_o), 32'h055);

    // R13 task priority
    wr(ad(8'h08), 32'hDEAD_BE7F);
    rdreg(ad(8'h08), rd); chk(rd == 32'h7F, "R13 tpr", rd, 32'h7F);

    // R6 arrays, first and last words, and ignored writes
    isr_bits = '0; tmr_bits = '0; irr_bits = '0;
    isr_bits[31:0] = 32'h1111_0001; isr_bits[255:224] = 32'h8000_0002;
    tmr_bits[31:0] = 32'h2222_0003; tmr_bits[255:224] = 32'h4000_0004;
    irr_bits[31:0] = 32'h3333_0005; irr_bits[255:224] = 32'h2000_0006;
    rdreg(ad(8'h10), rd); chk(rd == 32'h1111_0001, "R6 isr0", rd, 32'h1111_0001);
    rdreg(ad(8'h17), rd); chk(rd == 32'h8000_0002, "R6 isr7", rd, 32'h8000_0002);
    rdreg(ad(8'h18), rd); chk(rd == 32'h2222_0003, "R6 tmr0", rd, 32'h2222_0003);
    rdreg(ad(8'h1F), rd); chk(rd == 32'h4000_0004, "R6 tmr7", rd, 32'h4000_0004);
    rdreg(ad(8'h20), rd); chk(rd == 32'h3333_0005, "R6 irr0", rd, 32'h3333_0005);
    rdreg(ad(8'h27), rd); chk(rd == 32'h2000_0006, "R6 irr7", rd, 32'h2000_0006);
    wr(ad(8'h10), 32'hFFFF_FFFF); wr(ad(8'h28), 32'hFF); wr(ad(8'h39), 32'h1234);
    rdreg(ad(8'h28), rd); chk(rd == 0, "R6 esr untouched", rd, 0);

    // R11 narrow accesses
    wr(ad(8'h02), 32'h1100_0000, 4'h7);
    rdreg(ad(8'h02), rd); chk(rd == 32'hA500_0000, "R11 narrow write", rd, 32'hA500_0000);
    wr(ad(8'h0B), 0, 4'h1); chk(p_eoi == 0, "R11 narrow eoi", 32'(p_eoi), 0);
    rdreg(ad(8'h02), rd, 4'hC); chk(rd == 0, "R11 narrow read", rd, 0);
    rdreg(ad(8'h05), rd, 4'h3); chk(esr_o == 0, "R11 narrow no error", 32'(esr_o), 0);

    // R10 eoi, ppr, arbitration
    wr(ad(8'h0B), 32'h0); chk(p_eoi == 1, "R10 eoi pulse", 32'(p_eoi), 1);
    @(negedge clk); chk(eoi_o == 0, "R10 eoi one cycle", 32'(eoi_o), 0);
    rdreg(ad(8'h0B), rd); chk(rd == 0, "R10 eoi read", rd, 0);
    ppr_val = 8'hB0;
    rdreg(ad(8'h0A), rd); chk(rd == 32'hB0, "R10 ppr", rd, 32'hB0);
    rdreg(ad(8'h09), rd); chk(rd == 0, "R10 apr", rd, 0);

    // R7 command send
    wr(ad(8'h31), 32'h7E00_0000);
    wr(ad(8'h30), 32'h0000_8D41);
    chk(p_send == 1, "R7 send pulse", 32'(p_send), 1);
    chk(send_dest_o == 8'h7E, "R7 dest", 32'(send_dest_o), 32'h7E);
    chk(send_vec_o == 8'h41, "R7 vector", 32'(send_vec_o), 32'h41);
    chk(send_dmode_o == 3'd5, "R7 dmode", 32'(send_dmode_o), 5);
    chk(send_destmode_o == 1 && send_trig_o == 1, "R7 modes",
        {30'h0, send_destmode_o, send_trig_o}, 3);
    @(negedge clk); chk(send_o == 0, "R7 one cycle", 32'(send_o), 0);
    rdreg(ad(8'h30), rd); chk(rd == 32'h0000_8D41, "R7 low readback", rd, 32'h8D41);
    rdreg(ad(8'h31), rd); chk(rd == 32'h7E00_0000, "R7 high readback", rd, 32'h7E00_0000);

    // R8 divide: all sixteen values
    for (int v = 0; v < 16; v++) begin
      dv = 4'(v);
      wr(ad(8'h3E), {28'hFFFFFFF, dv});
      rdreg(ad(8'h3E), rd);
      chk(rd == 32'(dv & 4'hB), "R8 div keep", rd, 32'(dv & 4'hB));
      chk(div_shift_o == exp_shift(dv), "R8 shift", 32'(div_shift_o), 32'(exp_shift(dv)));
    end

    // R12 table edge and timer
    wr(ad(8'h37), 32'hCAFE_0037); exp_lvt[5] = 32'hCAFE_0037;
    chk(p_lvt == 6'b100000, "R12 lvt pulse", 32'(p_lvt), 32'h20);
    wr(ad(8'h38), 32'h0000_1000);
    chk(p_init == 1, "R12 init pulse", 32'(p_init), 1);
    chk(init_count_o == 32'h1000, "R12 init", init_count_o, 32'h1000);
    cur_count = 32'h0ABC_DEF0;
    rdreg(ad(8'h39), rd); chk(rd == 32'h0ABC_DEF0, "R12 current", rd, 32'h0ABC_DEF0);

    // random register traffic against the model
    for (int i = 0; i < 200; i++) begin
      int n; logic [31:0] d;
      n = int'($urandom_range(0, NL - 1));
      d = $urandom;
      wr(ad(8'h32 + n), d); exp_lvt[n] = d;
      chk(p_lvt == NL'(1 << n), "R12 random pulse", 32'(p_lvt), 32'(1 << n));
      n = int'($urandom_range(0, NL - 1));
      rdreg(ad(8'h32 + n), rd); chk(rd == exp_lvt[n], "R12 random lvt", rd, exp_lvt[n]);
      d = $urandom;
      wr(ad(8'h08), d);
      rdreg(ad(8'h08), rd); chk(rd == {24'h0, d[7:0]}, "R13 random tpr", rd, {24'h0, d[7:0]});
    end
    chk(esr_o == 0, "R9 no error yet", 32'(esr_o), 0);

    // R9 illegal indices
    rdreg(ad(8'h05), rd); chk(rd == 0, "R9 bad read data", rd, 0);
    chk(esr_o == 8'h80, "R9 set on read", 32'(esr_o), 32'h80);
    wr(ad(8'h3F), 32'h1); wr(ad(8'h28), 32'h0);
    rdreg(ad(8'h28), rd); chk(rd == 32'h80, "R9 sticky", rd, 32'h80);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule